// File: doc/BRIEF.md
# ID-Stage Branch Resolver with Forwarding

This block holds the hazard, forwarding and branch-resolution logic of a five-stage in-order RISC pipeline. Conditional branches (equal and not-equal) are settled in the decode stage. A bitwise XOR of the two source operands, reduced by an AND of the inverted bits, gives the equality result. The branch target is formed in the same stage, and the fetch address selector is steered there. The comparator operands come from the register file read ports. When a non-load result for the same register is waiting in the EX/MEM register, that result is used instead.

The block also drives the ALU operand multiplexer selects for the instruction in EX, taking data from either EX/MEM or MEM/WB. Some hazards cannot be covered by forwarding. In those cases the block raises a stall, which holds the PC and IF/ID and puts a bubble into ID/EX. A mode input sets how the slot after a taken branch is handled. With the mode low, the slot always executes. With the mode high, the branch is assumed not taken, and a taken branch flushes the instruction in IF. The register file writes before it reads within a cycle, so a value in WB needs no forwarding. All outputs are combinational functions of the present inputs.

Top module: `id_branch_resolver`

## Requirements
- R1: A branch is taken when `id_beq`=1 and the two comparator operands are equal, or when `id_bne`=1 and they differ. The two opcode inputs are never both 1. `br_taken` is 0 when neither is set.
- R2: `br_target` equals `id_pc` + 8 + 4 × `id_offset`, where `id_offset` is a two's-complement word offset extended by its sign bit.
- R3: When `exmem_regwrite`=1, `exmem_memread`=0 and `exmem_rd` is nonzero, a comparator operand whose specifier matches `exmem_rd` uses `exmem_result` in place of the register file data.
- R4: A branch whose used source matches the nonzero destination of a writing instruction in EX is stalled for one cycle. On the next cycle it resolves using the EX/MEM value.
- R5: A branch whose used source matches the nonzero destination of a load is stalled while the load is in EX and again while it is in MEM, which is two cycles. It resolves once the load reaches WB.
- R6: A load in EX whose nonzero destination matches a source of the ID instruction that is flagged as used raises `stall`. A matching source that is flagged unused is ignored.
- R7: `fwd_a_sel`/`fwd_b_sel` encode 2'b10 for EX/MEM, 2'b01 for MEM/WB and 2'b00 for no forwarding. These selects are for `ex_rs`/`ex_rt`. EX/MEM wins when both stages match. A load sitting in EX/MEM is never a forwarding source.
- R8: A destination of register 0 never produces a forwarding select, a comparator forward or a stall.
- R9: While `stall`=1: `pc_sel`=2'b10 (hold), `br_taken`=0 and `if_flush`=0.
- R10: With `slot_flush_mode`=0, `if_flush` stays 0. A taken branch still sets `pc_sel`=2'b01.
- R11: With `slot_flush_mode`=1, `if_flush`=1 exactly when `br_taken`=1.
- R12: Without a stall or a taken branch, `pc_sel`=2'b00 (sequential).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by checks only) |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_flush_mode | input | 1 | 1: not-taken assumption, flush IF on taken; 0: slot executes |
| id_beq | input | 1 | ID holds a branch-if-equal |
| id_bne | input | 1 | ID holds a branch-if-not-equal |
| id_pc | input | 32 | Address of the ID instruction |
| id_offset | input | 16 | Signed branch word offset |
| id_rs | input | 5 | First source specifier in ID |
| id_rt | input | 5 | Second source specifier in ID |
| id_rs_used | input | 1 | ID instruction reads id_rs |
| id_rt_used | input | 1 | ID instruction reads id_rt |
| rf_rs_data | input | 32 | Register file data for id_rs |
| rf_rt_data | input | 32 | Register file data for id_rt |
| ex_rs | input | 5 | First source specifier in EX |
| ex_rt | input | 5 | Second source specifier in EX |
| ex_rd | input | 5 | Destination specifier in EX |
| ex_regwrite | input | 1 | EX instruction writes a register |
| ex_memread | input | 1 | EX instruction is a load |
| exmem_rd | input | 5 | Destination in EX/MEM |
| exmem_regwrite | input | 1 | EX/MEM instruction writes a register |
| exmem_memread | input | 1 | EX/MEM instruction is a load |
| exmem_result | input | 32 | ALU result held in EX/MEM |
| memwb_rd | input | 5 | Destination in MEM/WB |
| memwb_regwrite | input | 1 | MEM/WB instruction writes a register |
| fwd_a_sel | output | 2 | ALU operand A select |
| fwd_b_sel | output | 2 | ALU operand B select |
| br_taken | output | 1 | Branch in ID is taken |
| pc_sel | output | 2 | 00 sequential, 01 branch target, 10 hold |
| br_target | output | 32 | Branch target address |
| stall | output | 1 | Hold PC and IF/ID, bubble into ID/EX |
| if_flush | output | 1 | Squash the instruction in IF |

## Verification
The collision that matters most is a stall and a branch decision arriving in the same cycle. The bench provokes it by placing a branch with equal operands behind a writer in EX, and then behind a load in EX and in MEM. In those cycles the branch must not be taken and the PC must be held, even though the comparator would report equality. After the stall cycles, the same branch must resolve using the EX/MEM value or the register file. A second pairing is EX/MEM and MEM/WB both matching an ALU source, where EX/MEM must win. A cycle-level model in the bench judges every output on every clock, including under random stimulus drawn from a small register set so that such overlaps occur often.

// File: rtl/idbr_pkg.sv
// Shared encodings for the ID-stage branch resolver.
package idbr_pkg;
    typedef enum logic [1:0] {
        FWD_NONE  = 2'b00,
        FWD_MEMWB = 2'b01,
        FWD_EXMEM = 2'b10
    } fwd_sel_e;

    typedef enum logic [1:0] {
        PCS_SEQ    = 2'b00,
        PCS_BRANCH = 2'b01,
        PCS_HOLD   = 2'b10
    } pc_sel_e;
endpackage

// File: rtl/idbr_alu_fwd.sv
// ALU operand forwarding select for one EX source operand.
// Assumes: a load in EX/MEM has no data yet, so it is skipped; the
// hazard unit guarantees a dependent instruction never meets it there.
module idbr_alu_fwd
    import idbr_pkg::*;
#(
    parameter int RAW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] src,
    input  logic [RAW-1:0] exmem_rd,
    input  logic           exmem_we,
    input  logic           exmem_ld,
    input  logic [RAW-1:0] memwb_rd,
    input  logic           memwb_we,
    output logic [1:0]     sel
);
    logic from_exmem;
    logic from_memwb;

    // Match each later stage against the operand, ignoring register 0.
    always_comb begin
        from_exmem = exmem_we && !exmem_ld && (exmem_rd != '0) && (exmem_rd == src);
        from_memwb = memwb_we && (memwb_rd != '0) && (memwb_rd == src);
    end

    // Younger result (EX/MEM) has priority over MEM/WB.
    always_comb begin
        if (from_exmem)      sel = FWD_EXMEM;
        else if (from_memwb) sel = FWD_MEMWB;
        else                 sel = FWD_NONE;
    end

    a_r7_exmem_sel_source: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == FWD_EXMEM) |-> (exmem_rd == src && exmem_we && !exmem_ld));
    a_r8_no_reg0_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != FWD_NONE) |-> (src != '0));
endmodule

// File: rtl/idbr_hazard.sv
// Stall detection for hazards that forwarding cannot cover.
// Covers: load-use in EX, any writer in EX feeding a branch, and a load
// in MEM feeding a branch (comparator taps only EX/MEM ALU results).
// Assumes the register file writes before it reads, so WB needs nothing.
module idbr_hazard #(
    parameter int RAW  = 5,
    parameter int NSRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0][RAW-1:0] id_src,
    input  logic [NSRC-1:0]          id_src_used,
    input  logic                     id_is_branch,
    input  logic [RAW-1:0]           ex_rd,
    input  logic                     ex_we,
    input  logic                     ex_ld,
    input  logic [RAW-1:0]           exmem_rd,
    input  logic                     exmem_we,
    input  logic                     exmem_ld,
    output logic                     stall
);
    logic [NSRC-1:0] hit_ex;
    logic [NSRC-1:0] hit_mem_ld;

    // Per-source dependency on the EX and MEM stages.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_comb begin
            hit_ex[g]     = id_src_used[g] && ex_we && (ex_rd != '0) && (ex_rd == id_src[g]);
            hit_mem_ld[g] = id_src_used[g] && exmem_we && exmem_ld &&
                            (exmem_rd != '0) && (exmem_rd == id_src[g]);
        end
    end

    // Combine the three stall causes.
    always_comb begin
        stall = (ex_ld && (|hit_ex))
              || (id_is_branch && (|hit_ex))
              || (id_is_branch && (|hit_mem_ld));
    end

    a_r6_load_use_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ld && ex_we && ex_rd != '0 && id_src_used[0] && ex_rd == id_src[0]) |-> stall);
    a_r5_load_in_mem_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_branch && exmem_ld && exmem_we && exmem_rd != '0 &&
         id_src_used[NSRC-1] && exmem_rd == id_src[NSRC-1]) |-> stall);
    a_r8_reg0_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0 && exmem_rd == '0) |-> !stall);
endmodule

// File: rtl/idbr_branch.sv
// Decode-stage branch comparator and target adder.
// Operands come from the register file or, for a non-load in EX/MEM with
// a matching destination, from the EX/MEM result. Equality is an XOR per
// bit followed by an AND of the inverted differences.
module idbr_branch #(
    parameter int XLEN  = 32,
    parameter int RAW   = 5,
    parameter int OFS_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0][RAW-1:0]   id_src,
    input  logic [1:0][XLEN-1:0]  rf_data,
    input  logic [RAW-1:0]        exmem_rd,
    input  logic                  exmem_we,
    input  logic                  exmem_ld,
    input  logic [XLEN-1:0]       exmem_result,
    input  logic                  is_beq,
    input  logic                  is_bne,
    input  logic                  stall,
    input  logic [XLEN-1:0]       id_pc,
    input  logic [OFS_W-1:0]      id_offset,
    output logic                  taken,
    output logic [XLEN-1:0]       target
);
    localparam int EXT_W = XLEN - OFS_W - 2;

    logic [1:0][XLEN-1:0] opnd;
    logic [XLEN-1:0]      diff;
    logic                 equal;

    // Comparator operand forwarding from EX/MEM.
    for (genvar g = 0; g < 2; g++) begin : g_opnd
        always_comb begin
            if (exmem_we && !exmem_ld && (exmem_rd != '0) && (exmem_rd == id_src[g]))
                opnd[g] = exmem_result;
            else
                opnd[g] = rf_data[g];
        end
    end

    // Bitwise XOR array of the comparator.
    for (genvar b = 0; b < XLEN; b++) begin : g_xor
        assign diff[b] = opnd[0][b] ^ opnd[1][b];
    end

    // AND reduction of inverted differences and branch decision.
    always_comb begin
        equal = &(~diff);
        taken = (is_beq || is_bne) && !stall && (equal ^ is_bne);
    end

    // Target: branch address plus 8 plus the scaled signed offset.
    always_comb begin
        target = id_pc + XLEN'(8) + {{EXT_W{id_offset[OFS_W-1]}}, id_offset, 2'b00};
    end

    a_r1_taken_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (is_beq || is_bne));
    a_r1_opcode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_beq && is_bne));
    a_r9_no_decision_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !taken);
endmodule

// File: rtl/id_branch_resolver.sv
// Top of the ID-stage branch resolver: ALU operand forwarding selects,
// stall detection, branch decision, target and PC/flush steering.
// Assumes at most one of id_beq/id_bne is set and that the PC, IF/ID
// and ID/EX registers outside honour stall, pc_sel and if_flush.
module id_branch_resolver
    import idbr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int RAW   = 5,
    parameter int OFS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_flush_mode,
    input  logic             id_beq,
    input  logic             id_bne,
    input  logic [XLEN-1:0]  id_pc,
    input  logic [OFS_W-1:0] id_offset,
    input  logic [RAW-1:0]   id_rs,
    input  logic [RAW-1:0]   id_rt,
    input  logic             id_rs_used,
    input  logic             id_rt_used,
    input  logic [XLEN-1:0]  rf_rs_data,
    input  logic [XLEN-1:0]  rf_rt_data,
    input  logic [RAW-1:0]   ex_rs,
    input  logic [RAW-1:0]   ex_rt,
    input  logic [RAW-1:0]   ex_rd,
    input  logic             ex_regwrite,
    input  logic             ex_memread,
    input  logic [RAW-1:0]   exmem_rd,
    input  logic             exmem_regwrite,
    input  logic             exmem_memread,
    input  logic [XLEN-1:0]  exmem_result,
    input  logic [RAW-1:0]   memwb_rd,
    input  logic             memwb_regwrite,
    output logic [1:0]       fwd_a_sel,
    output logic [1:0]       fwd_b_sel,
    output logic             br_taken,
    output logic [1:0]       pc_sel,
    output logic [XLEN-1:0]  br_target,
    output logic             stall,
    output logic             if_flush
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][RAW-1:0]  ex_src;
    logic [NSRC-1:0][1:0]      fwd_sel;
    logic [NSRC-1:0][RAW-1:0]  id_src;
    logic [NSRC-1:0]           id_used;
    logic [NSRC-1:0][XLEN-1:0] rf_data;

    // Gather per-operand vectors for the repeated units.
    always_comb begin
        ex_src  = {ex_rt, ex_rs};
        id_src  = {id_rt, id_rs};
        id_used = {id_rt_used, id_rs_used};
        rf_data = {rf_rt_data, rf_rs_data};
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_fwd
        idbr_alu_fwd #(.RAW(RAW)) u_fwd (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (ex_src[g]),
            .exmem_rd (exmem_rd),
            .exmem_we (exmem_regwrite),
            .exmem_ld (exmem_memread),
            .memwb_rd (memwb_rd),
            .memwb_we (memwb_regwrite),
            .sel      (fwd_sel[g])
        );
    end

    assign fwd_a_sel = fwd_sel[0];
    assign fwd_b_sel = fwd_sel[1];

    idbr_hazard #(.RAW(RAW), .NSRC(NSRC)) u_hazard (
        .clk          (clk),
        .rst_n        (rst_n),
        .id_src       (id_src),
        .id_src_used  (id_used),
        .id_is_branch (id_beq || id_bne),
        .ex_rd        (ex_rd),
        .ex_we        (ex_regwrite),
        .ex_ld        (ex_memread),
        .exmem_rd     (exmem_rd),
        .exmem_we     (exmem_regwrite),
        .exmem_ld     (exmem_memread),
        .stall        (stall)
    );

    idbr_branch #(.XLEN(XLEN), .RAW(RAW), .OFS_W(OFS_W)) u_branch (
        .clk          (clk),
        .rst_n        (rst_n),
        .id_src       (id_src),
        .rf_data      (rf_data),
        .exmem_rd     (exmem_rd),
        .exmem_we     (exmem_regwrite),
        .exmem_ld     (exmem_memread),
        .exmem_result (exmem_result),
        .is_beq       (id_beq),
        .is_bne       (id_bne),
        .stall        (stall),
        .id_pc        (id_pc),
        .id_offset    (id_offset),
        .taken        (br_taken),
        .target       (br_target)
    );

    // Fetch address steering: hold beats redirect beats sequential.
    always_comb begin
        if (stall)         pc_sel = PCS_HOLD;
        else if (br_taken) pc_sel = PCS_BRANCH;
        else               pc_sel = PCS_SEQ;
    end

    // Squash the fetched slot only under the not-taken assumption.
    always_comb begin
        if_flush = br_taken && slot_flush_mode;
    end

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (pc_sel == PCS_HOLD && !if_flush));
    a_r10_slot_never_flushed: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_flush_mode |-> !if_flush);
    a_r11_flush_with_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_flush_mode && br_taken) |-> if_flush);
    a_r12_redirect_only_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == PCS_BRANCH) |-> br_taken);
endmodule

// File: tb/id_branch_resolver_test.sv
`timescale 1ns/1ps
module id_branch_resolver_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        slot_flush_mode, id_beq, id_bne, id_rs_used, id_rt_used;
    logic [31:0] id_pc, rf_rs_data, rf_rt_data, exmem_result;
    logic [15:0] id_offset;
    logic [4:0]  id_rs, id_rt, ex_rs, ex_rt, ex_rd, exmem_rd, memwb_rd;
    logic        ex_regwrite, ex_memread, exmem_regwrite, exmem_memread, memwb_regwrite;
    logic [1:0]  fwd_a_sel, fwd_b_sel, pc_sel;
    logic        br_taken, stall, if_flush;
    logic [31:0] br_target;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    id_branch_resolver uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        slot_flush_mode = 0; id_beq = 0; id_bne = 0; id_rs_used = 0; id_rt_used = 0;
        id_pc = 32'h100; id_offset = 0; id_rs = 0; id_rt = 0;
        rf_rs_data = 0; rf_rt_data = 0; exmem_result = 0;
        ex_rs = 0; ex_rt = 0; ex_rd = 0; ex_regwrite = 0; ex_memread = 0;
        exmem_rd = 0; exmem_regwrite = 0; exmem_memread = 0;
        memwb_rd = 0; memwb_regwrite = 0;
    endtask

    task automatic next_cycle();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic set_branch(input bit ne, input logic [4:0] a, input logic [4:0] b);
        id_beq = !ne; id_bne = ne; id_rs = a; id_rt = b; id_rs_used = 1; id_rt_used = 1;
    endtask

    // Behavioural reference model of every output.
    logic [1:0]  e_fa, e_fb, e_pc;
    logic        e_tk, e_st, e_fl;
    logic [31:0] e_tg;

    function automatic logic [1:0] ref_fwd(input logic [4:0] s);
        if (s == 0) return 2'b00;
        if (exmem_regwrite && !exmem_memread && exmem_rd == s) return 2'b10;
        if (memwb_regwrite && memwb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [31:0] ref_opnd(input logic [4:0] s, input logic [31:0] rf);
        if (s != 0 && exmem_regwrite && !exmem_memread && exmem_rd == s) return exmem_result;
        return rf;
    endfunction

    task automatic ref_model();
        bit is_br, dep_ex, dep_ld_mem;
        is_br = id_beq || id_bne;
        dep_ex = 0; dep_ld_mem = 0;
        if (ex_regwrite && ex_rd != 0) begin
            if (id_rs_used && id_rs == ex_rd) dep_ex = 1;
            if (id_rt_used && id_rt == ex_rd) dep_ex = 1;
        end
        if (exmem_regwrite && exmem_memread && exmem_rd != 0) begin
            if (id_rs_used && id_rs == exmem_rd) dep_ld_mem = 1;
            if (id_rt_used && id_rt == exmem_rd) dep_ld_mem = 1;
        end
        e_st = (dep_ex && (ex_memread || is_br)) || (dep_ld_mem && is_br);
        e_tk = 0;
        if (is_br && !e_st) begin
            if ((ref_opnd(id_rs, rf_rs_data) == ref_opnd(id_rt, rf_rt_data)) != id_bne) e_tk = 1;
        end
        e_pc = e_st ? 2'b10 : (e_tk ? 2'b01 : 2'b00);
        e_fl = e_tk && slot_flush_mode;
        e_tg = id_pc + 8 + 4 * {{16{id_offset[15]}}, id_offset};
        e_fa = ref_fwd(ex_rs);
        e_fb = ref_fwd(ex_rt);
    endtask

    task automatic compare_all(input string ctx);
        ref_model();
        chk({ctx, " R7 fwd_a"}, 32'(fwd_a_sel), 32'(e_fa));
        chk({ctx, " R7 fwd_b"}, 32'(fwd_b_sel), 32'(e_fb));
        chk({ctx, " R6 stall"}, 32'(stall), 32'(e_st));
        chk({ctx, " R1 taken"}, 32'(br_taken), 32'(e_tk));
        chk({ctx, " R12 pc_sel"}, 32'(pc_sel), 32'(e_pc));
        chk({ctx, " R11 flush"}, 32'(if_flush), 32'(e_fl));
        chk({ctx, " R2 target"}, br_target, e_tg);
    endtask

    function automatic logic [31:0] pick_data();
        case ($urandom_range(0, 2))
            0: return 32'h0;
            1: return 32'h5;
            default: return 32'hA5A5_0F0F;
        endcase
    endfunction

    initial begin
        int stalls;
        idle();
        repeat (3) @(posedge clk);
        settle();
        chk("R12 reset pc_sel", 32'(pc_sel), 32'd0);
        chk("R12 reset stall", 32'(stall), 32'd0);
        chk("R11 reset flush", 32'(if_flush), 32'd0);
        next_cycle(); rst_n = 1;

        // R1/R2: BEQ equal taken, positive offset.
        next_cycle(); idle(); slot_flush_mode = 1; id_pc = 32'd100; id_offset = 16'd10;
        set_branch(0, 5'd1, 5'd2); rf_rs_data = 32'h77; rf_rt_data = 32'h77;
        settle();
        chk("R1 beq equal taken", 32'(br_taken), 32'd1);
        chk("R2 target +10", br_target, 32'd148);
        chk("R11 flush on taken", 32'(if_flush), 32'd1);
        compare_all("dir beq");

        // R1/R2: BNE, negative offset.
        next_cycle(); id_offset = 16'hFFF6; set_branch(1, 5'd1, 5'd2);
        settle();
        chk("R1 bne equal not taken", 32'(br_taken), 32'd0);
        chk("R2 target -10", br_target, 32'd68);
        next_cycle(); rf_rt_data = 32'h78;
        settle();
        chk("R1 bne differ taken", 32'(br_taken), 32'd1);

        // R10: slot mode keeps the slot.
        next_cycle(); slot_flush_mode = 0;
        settle();
        chk("R10 no flush in slot mode", 32'(if_flush), 32'd0);
        chk("R10 redirect in slot mode", 32'(pc_sel), 32'd1);

        // R3: comparator takes EX/MEM over stale register file.
        next_cycle(); idle(); set_branch(0, 5'd3, 5'd4);
        rf_rs_data = 32'h1; rf_rt_data = 32'h99;
        exmem_rd = 5'd3; exmem_regwrite = 1; exmem_result = 32'h99;
        settle();
        chk("R3 comparator forward", 32'(br_taken), 32'd1);

        // R4 + R9: ALU in EX feeding branch, then forwarded next cycle.
        next_cycle(); idle(); slot_flush_mode = 1; set_branch(0, 5'd3, 5'd4);
        rf_rs_data = 32'h1; rf_rt_data = 32'h1;
        ex_rd = 5'd3; ex_regwrite = 1;
        settle();
        chk("R4 alu->branch stall", 32'(stall), 32'd1);
        chk("R9 no taken in stall", 32'(br_taken), 32'd0);
        chk("R9 hold pc", 32'(pc_sel), 32'd2);
        chk("R9 no flush in stall", 32'(if_flush), 32'd0);
        next_cycle(); ex_rd = 0; ex_regwrite = 0;
        exmem_rd = 5'd3; exmem_regwrite = 1; exmem_result = 32'h1; rf_rs_data = 32'h0;
        settle();
        chk("R4 resolved after one stall", 32'(stall), 32'd0);
        chk("R4 taken via EX/MEM", 32'(br_taken), 32'd1);

        // R5: load feeding branch stalls two cycles.
        next_cycle(); idle(); set_branch(1, 5'd2, 5'd4);
        rf_rs_data = 32'h0; rf_rt_data = 32'h8;
        stalls = 0;
        ex_rd = 5'd4; ex_regwrite = 1; ex_memread = 1;
        settle(); if (stall) stalls++;
        next_cycle(); ex_rd = 0; ex_regwrite = 0; ex_memread = 0;
        exmem_rd = 5'd4; exmem_regwrite = 1; exmem_memread = 1; exmem_result = 32'h40;
        settle(); if (stall) stalls++;
        chk("R5 no decision while load in MEM", 32'(br_taken), 32'd0);
        next_cycle(); exmem_rd = 0; exmem_regwrite = 0; exmem_memread = 0;
        memwb_rd = 5'd4; memwb_regwrite = 1; rf_rt_data = 32'h3;
        settle();
        chk("R5 stall cycles", 32'(stalls), 32'd2);
        chk("R5 resolves at WB", 32'(br_taken), 32'd1);

        // R6: load-use on a used source; unused source ignored.
        next_cycle(); idle(); id_rt = 5'd5; id_rt_used = 1;
        ex_rd = 5'd5; ex_regwrite = 1; ex_memread = 1;
        settle();
        chk("R6 load-use stall", 32'(stall), 32'd1);
        next_cycle(); id_rt_used = 0;
        settle();
        chk("R6 unused source ignored", 32'(stall), 32'd0);
        chk("R6 unused source pc", 32'(pc_sel), 32'd0);

        // R7: forwarding priority and load skip.
        next_cycle(); idle(); ex_rs = 5'd6; ex_rt = 5'd7;
        exmem_rd = 5'd6; exmem_regwrite = 1; memwb_rd = 5'd6; memwb_regwrite = 1;
        settle();
        chk("R7 exmem priority", 32'(fwd_a_sel), 32'd2);
        chk("R7 no match b", 32'(fwd_b_sel), 32'd0);
        next_cycle(); exmem_memread = 1;
        settle();
        chk("R7 load in exmem skipped", 32'(fwd_a_sel), 32'd1);

        // R8: register 0 destinations never act.
        next_cycle(); idle(); ex_rs = 0; ex_rt = 0;
        exmem_regwrite = 1; memwb_regwrite = 1;
        ex_regwrite = 1; ex_memread = 1; set_branch(0, 5'd0, 5'd0);
        rf_rs_data = 32'h0; rf_rt_data = 32'h0; exmem_result = 32'h5;
        settle();
        chk("R8 no fwd from r0", 32'(fwd_a_sel), 32'd0);
        chk("R8 no stall from r0", 32'(stall), 32'd0);
        chk("R8 no comparator fwd from r0", 32'(br_taken), 32'd1);

        // Random stimulus with a small register set, compared every cycle.
        for (int i = 0; i < 600; i++) begin
            next_cycle();
            slot_flush_mode = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 2))
                0: begin id_beq = 1; id_bne = 0; end
                1: begin id_beq = 0; id_bne = 1; end
                default: begin id_beq = 0; id_bne = 0; end
            endcase
            id_pc = $urandom & 32'hFFFF_FFFC; id_offset = 16'($urandom);
            id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
            id_rs_used = 1'($urandom_range(0, 1)); id_rt_used = 1'($urandom_range(0, 1));
            rf_rs_data = pick_data(); rf_rt_data = pick_data(); exmem_result = pick_data();
            ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3));
            ex_rd = 5'($urandom_range(0, 3)); ex_regwrite = 1'($urandom_range(0, 1));
            ex_memread = 1'($urandom_range(0, 1));
            exmem_rd = 5'($urandom_range(0, 3)); exmem_regwrite = 1'($urandom_range(0, 1));
            exmem_memread = 1'($urandom_range(0, 1));
            memwb_rd = 5'($urandom_range(0, 3)); memwb_regwrite = 1'($urandom_range(0, 1));
            settle();
            compare_all("rand");
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule